// File: doc/BRIEF.md
# Physical Address Region Decoder

This block sorts each memory request by where it falls in the physical address space. It sends the request to one of four targets: main RAM, a boot ROM that holds the reset vector, a timer and interrupt register block, or a single host-communication register. The base and span of each region are fixed when the block is elaborated. A request carries an address, a byte count and a direction flag. The block answers in the same cycle with one select line per target. When no target accepts the request, it raises an access fault, and the fault is reported separately for reads and writes.

A request is accepted by a region only if every byte it touches lies inside that region. The host register is different: it accepts a request only when the address equals its configured address exactly, and it applies a separate width limit for each direction. The end address of a request is computed one bit wider than the address bus. As a result, a request that runs past the top of the address space can never match a region by wrapping around to zero.

Top module: `phys_region_decoder`

## Requirements
- R1: A valid request selects RAM when RAM_BASE <= addr and addr + bytes <= RAM_BASE + RAM_SIZE, both compared as unsigned values. This holds even when RAM ends exactly at the top of the address space.
- R2: A valid request selects ROM under the same full-containment rule, using ROM_BASE and ROM_SIZE. A request that starts below the base, or whose last byte lies past the end, does not select ROM.
- R3: A valid request selects the timer block under the same full-containment rule, using TMR_BASE and TMR_SIZE.
- R4: The host register is selected only when addr equals HOST_ADDR exactly. A write is accepted only when bytes <= HOST_WR_MAX (default 8). A read is accepted only when bytes >= HOST_RD_MIN (default 1).
- R5: At most one select is high at any time. When several targets accept the same request, the fixed priority is RAM, then ROM, then the timer block, then the host register.
- R6: A valid read that no target accepts raises fault_load only. A valid write that no target accepts raises fault_store only. A fault is never raised together with a select.
- R7: The end address is formed one bit wider than the address bus. A request whose bytes run past the top of the address space therefore matches no region and faults.
- R8: While req_valid is low, every select and both fault outputs are low, whatever the address.
- R9: A request with bytes equal to 0 selects no target and raises the fault for its direction.
- R10: All outputs depend only on the current request, with no register on the path. They are valid in the same cycle the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | A request is present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address of the first byte |
| req_bytes | input | BYTES_W | Number of bytes accessed |
| sel_ram | output | 1 | Request routed to main RAM |
| sel_rom | output | 1 | Request routed to boot ROM |
| sel_timer | output | 1 | Request routed to the timer/interrupt block |
| sel_host | output | 1 | Request routed to the host register |
| fault_load | output | 1 | Read that no target accepts |
| fault_store | output | 1 | Write that no target accepts |

## Verification
No register lies between the request and any output, so every select and fault result is due in the same cycle the request is applied. The driver changes the request one nanosecond after a rising edge and pushes the expected six-bit result into a queue. The monitor pops that entry at the following falling edge, half a period later. At that point the combinational outputs have long settled and no input is changing. A second instance, whose host register sits inside the timer window, checks that the timer wins when both targets accept the same request.

// File: rtl/phys_region_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the physical address region decoder.
// Target indices also set the priority order: a lower index wins.
package phys_region_pkg;

    typedef enum logic [1:0] {
        TGT_RAM   = 2'd0,
        TGT_ROM   = 2'd1,
        TGT_TIMER = 2'd2,
        TGT_HOST  = 2'd3
    } target_e;

    localparam int unsigned NUM_TGT   = 4;
    localparam int unsigned NUM_RANGE = 3;   // RAM, ROM and timer use the containment rule

endpackage

// File: rtl/region_window_match.sv
`timescale 1ns/1ps
// region_window_match
// Reports whether a request of req_bytes bytes starting at req_addr lies
// entirely inside [BASE, BASE+SIZE).
// Assumes: BASE + SIZE fits in ADDR_W+1 bits. The caller gates out
// zero-byte and invalid requests.
module region_window_match #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned BYTES_W = 5,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] SIZE = '0
) (
    input  logic               req_qual,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    output logic               hit
);
    localparam int unsigned EXT_W = ADDR_W + 1;
    localparam logic [EXT_W-1:0] LIMIT = {1'b0, BASE} + {1'b0, SIZE};

    logic [EXT_W-1:0] end_addr;

    // Form the end address one bit wider so it cannot wrap to zero.
    always_comb begin
        end_addr = {1'b0, req_addr} + {{(EXT_W-BYTES_W){1'b0}}, req_bytes};
    end

    // Hit only when both the first byte and the end fall inside the window.
    always_comb begin
        hit = req_qual && (req_addr >= BASE) && (end_addr <= LIMIT);
    end

endmodule

// File: rtl/host_port_match.sv
`timescale 1ns/1ps
// host_port_match
// Matches the single host-communication register. It needs an exact
// address match, plus a per-direction width limit: reads need at least
// RD_MIN bytes, writes allow at most WR_MAX bytes.
// Assumes: the limits fit in BYTES_W bits.
module host_port_match #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned BYTES_W = 5,
    parameter logic [ADDR_W-1:0] ADDR = '0,
    parameter int unsigned RD_MIN  = 1,
    parameter int unsigned WR_MAX  = 8
) (
    input  logic               req_qual,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    output logic               hit
);
    localparam logic [BYTES_W-1:0] RD_MIN_L = BYTES_W'(RD_MIN);
    localparam logic [BYTES_W-1:0] WR_MAX_L = BYTES_W'(WR_MAX);

    logic width_ok;

    // Apply the width limit that belongs to the request's direction.
    always_comb begin
        width_ok = req_write ? (req_bytes <= WR_MAX_L) : (req_bytes >= RD_MIN_L);
    end

    // Exact address compare, qualified by the width limit.
    always_comb begin
        hit = req_qual && (req_addr == ADDR) && width_ok;
    end

endmodule

// File: rtl/target_priority.sv
`timescale 1ns/1ps
// target_priority
// Turns a vector of target hits into a one-hot grant. The lowest set
// index wins. Also reports whether any target was granted.
// Assumes: the index order is the priority order.
module target_priority #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] hit,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan from index 0 upward and block every hit after the first.
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            grant[i] = hit[i] && !taken;
            taken    = taken || hit[i];
        end
        any = taken;
    end

endmodule

// File: rtl/phys_region_decoder.sv
`timescale 1ns/1ps
// phys_region_decoder
// Routes a physical access to RAM, ROM, the timer block or the host
// register. Any unmatched access raises a direction-specific fault.
// The block is purely combinational.
// Assumes: region parameters fit the address width. Overlaps between
// regions are resolved by the fixed priority RAM > ROM > timer > host.
module phys_region_decoder
    import phys_region_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned BYTES_W = 5,
    parameter logic [ADDR_W-1:0] RAM_BASE  = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] RAM_SIZE  = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] ROM_SIZE  = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] TMR_BASE  = 32'h0200_0000,
    parameter logic [ADDR_W-1:0] TMR_SIZE  = 32'h0000_C000,
    parameter logic [ADDR_W-1:0] HOST_ADDR = 32'h4000_0000,
    parameter int unsigned HOST_RD_MIN = 1,
    parameter int unsigned HOST_WR_MAX = 8
) (
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    output logic               sel_ram,
    output logic               sel_rom,
    output logic               sel_timer,
    output logic               sel_host,
    output logic               fault_load,
    output logic               fault_store
);
    localparam logic [ADDR_W-1:0] WIN_BASE [NUM_RANGE] = '{RAM_BASE, ROM_BASE, TMR_BASE};
    localparam logic [ADDR_W-1:0] WIN_SIZE [NUM_RANGE] = '{RAM_SIZE, ROM_SIZE, TMR_SIZE};

    logic               req_qual;
    logic [NUM_TGT-1:0] tgt_hit;
    logic [NUM_TGT-1:0] tgt_grant;
    logic               tgt_any;

    // A request takes part in decoding only if it is valid and non-empty.
    always_comb begin
        req_qual = req_valid && (req_bytes != '0);
    end

    // One containment matcher per memory-like region.
    for (genvar g = 0; g < NUM_RANGE; g++) begin : g_win
        region_window_match #(
            .ADDR_W  (ADDR_W),
            .BYTES_W (BYTES_W),
            .BASE    (WIN_BASE[g]),
            .SIZE    (WIN_SIZE[g])
        ) u_win (
            .req_qual  (req_qual),
            .req_addr  (req_addr),
            .req_bytes (req_bytes),
            .hit       (tgt_hit[g])
        );
    end

    host_port_match #(
        .ADDR_W  (ADDR_W),
        .BYTES_W (BYTES_W),
        .ADDR    (HOST_ADDR),
        .RD_MIN  (HOST_RD_MIN),
        .WR_MAX  (HOST_WR_MAX)
    ) u_host (
        .req_qual  (req_qual),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_bytes (req_bytes),
        .hit       (tgt_hit[TGT_HOST])
    );

    target_priority #(
        .N (NUM_TGT)
    ) u_prio (
        .hit   (tgt_hit),
        .grant (tgt_grant),
        .any   (tgt_any)
    );

    // Drive the select outputs from the one-hot grant.
    always_comb begin
        sel_ram   = tgt_grant[TGT_RAM];
        sel_rom   = tgt_grant[TGT_ROM];
        sel_timer = tgt_grant[TGT_TIMER];
        sel_host  = tgt_grant[TGT_HOST];
    end

    // Report an unmatched valid request as a fault for its direction.
    always_comb begin
        fault_load  = req_valid && !req_write && !tgt_any;
        fault_store = req_valid &&  req_write && !tgt_any;
    end

endmodule

// File: rtl/phys_region_decoder_chk.sv
`timescale 1ns/1ps
// phys_region_decoder_chk
// Assertion checker bound to phys_region_decoder. It watches the ports
// only and uses immediate assertions, since the block has no clock.
module phys_region_decoder_chk #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned BYTES_W = 5,
    parameter logic [ADDR_W-1:0] RAM_BASE  = '0,
    parameter logic [ADDR_W-1:0] ROM_BASE  = '0,
    parameter logic [ADDR_W-1:0] TMR_BASE  = '0,
    parameter logic [ADDR_W-1:0] HOST_ADDR = '0,
    parameter int unsigned HOST_WR_MAX = 8
) (
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [BYTES_W-1:0] req_bytes,
    input logic               sel_ram,
    input logic               sel_rom,
    input logic               sel_timer,
    input logic               sel_host,
    input logic               fault_load,
    input logic               fault_store
);
    logic [3:0] sels;
    logic       known;

    // Gather the selects and skip checks while any input is unknown.
    always_comb begin
        sels  = {sel_ram, sel_rom, sel_timer, sel_host};
        known = !$isunknown({req_valid, req_write, req_addr, req_bytes});
    end

    // Evaluate the port-level properties on every input change.
    always_comb begin
        if (known) begin
            p_onehot_r5: assert ($onehot0(sels))
                else $error("more than one target selected");
            p_idle_quiet_r8: assert (req_valid || (sels == '0 && !fault_load && !fault_store))
                else $error("output active without a request");
            p_fault_excl_r6: assert (!(fault_load || fault_store) || sels == '0)
                else $error("fault raised together with a select");
            p_fault_dir_r6: assert ((!fault_load || !req_write) && (!fault_store || req_write))
                else $error("fault reported for the wrong direction");
            p_zero_bytes_r9: assert (req_bytes != '0 || sels == '0)
                else $error("zero-byte request selected a target");
            p_host_exact_r4: assert (!sel_host || (req_addr == HOST_ADDR &&
                                     (!req_write || req_bytes <= BYTES_W'(HOST_WR_MAX))))
                else $error("host selected off its address or over its write width");
            p_base_floor_r1: assert ((!sel_ram || req_addr >= RAM_BASE) &&
                                     (!sel_rom || req_addr >= ROM_BASE) &&
                                     (!sel_timer || req_addr >= TMR_BASE))
                else $error("region selected below its base");
        end
    end

endmodule

bind phys_region_decoder phys_region_decoder_chk #(
    .ADDR_W      (ADDR_W),
    .BYTES_W     (BYTES_W),
    .RAM_BASE    (RAM_BASE),
    .ROM_BASE    (ROM_BASE),
    .TMR_BASE    (TMR_BASE),
    .HOST_ADDR   (HOST_ADDR),
    .HOST_WR_MAX (HOST_WR_MAX)
) u_chk (
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_bytes   (req_bytes),
    .sel_ram     (sel_ram),
    .sel_rom     (sel_rom),
    .sel_timer   (sel_timer),
    .sel_host    (sel_host),
    .fault_load  (fault_load),
    .fault_store (fault_store)
);

// File: tb/phys_region_decoder_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies a request and queues the expected
// outputs of both instances; the monitor compares them half a period later.
module phys_region_decoder_bench;

    localparam logic [31:0] OVL_HOST = 32'h0200_4000;  // inside the timer window

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_bytes = '0;

    logic [5:0]  out_a;
    logic [5:0]  out_b;

    typedef struct {
        logic [5:0] exp_a;
        logic [5:0] exp_b;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    phys_region_decoder u_phys_region_decoder (
        .req_valid (req_valid), .req_write (req_write),
        .req_addr  (req_addr),  .req_bytes (req_bytes),
        .sel_ram   (out_a[5]),  .sel_rom   (out_a[4]),
        .sel_timer (out_a[3]),  .sel_host  (out_a[2]),
        .fault_load(out_a[1]),  .fault_store(out_a[0])
    );

    phys_region_decoder #(.HOST_ADDR(OVL_HOST)) u_phys_region_decoder_ovl (
        .req_valid (req_valid), .req_write (req_write),
        .req_addr  (req_addr),  .req_bytes (req_bytes),
        .sel_ram   (out_b[5]),  .sel_rom   (out_b[4]),
        .sel_timer (out_b[3]),  .sel_host  (out_b[2]),
        .fault_load(out_b[1]),  .fault_store(out_b[0])
    );

    // Reference model from the requirements, in wide arithmetic.
    function automatic logic [5:0] model(input bit v, input bit w, input longint unsigned a,
                                         input longint unsigned n, input longint unsigned host);
        logic [3:0] hit;
        logic [3:0] sel;
        longint unsigned e;
        e = a + n;
        hit = '0;
        if (v && n != 0) begin
            hit[3] = (a >= 64'hF000_0000) && (e <= 64'h1_0000_0000);
            hit[2] = (a >= 64'h1000) && (e <= 64'h2000);
            hit[1] = (a >= 64'h0200_0000) && (e <= 64'h0200_C000);
            hit[0] = (a == host) && (w ? (n <= 8) : (n >= 1));
        end
        sel = hit[3] ? 4'b1000 : hit[2] ? 4'b0100 : hit[1] ? 4'b0010 : hit[0] ? 4'b0001 : 4'b0000;
        return {sel, v && !w && sel == 0, v && w && sel == 0};
    endfunction

    // Driver: apply a request after a rising edge and queue the expectations.
    task automatic drive(input bit v, input bit w, input logic [31:0] a,
                         input logic [4:0] n, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        req_valid = v; req_write = w; req_addr = a; req_bytes = n;
        it.exp_a = model(v, w, a, n, 64'h4000_0000);
        it.exp_b = model(v, w, a, n, OVL_HOST);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge, away from any input change.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total += 2;
                if (out_a !== it.exp_a) begin
                    bad++;
                    $display("FAIL %s main: got %b expected %b", it.tag, out_a, it.exp_a);
                end
                if (out_b !== it.exp_b) begin
                    bad++;
                    $display("FAIL %s overlap: got %b expected %b", it.tag, out_b, it.exp_b);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        drive(0, 0, 32'h0, 5'd0, "R8 reset idle");
        drive(0, 1, 32'hF000_0000, 5'd4, "R8 idle on RAM address");
        drive(1, 0, 32'hF000_0000, 5'd4, "R1 RAM base read (R10 same cycle)");
        drive(1, 1, 32'hFFFF_FFF8, 5'd8, "R1 R7 RAM ends at top");
        drive(1, 0, 32'hFFFF_FFFC, 5'd8, "R7 read past top");
        drive(1, 1, 32'hFFFF_FFFF, 5'd2, "R7 write wraps");
        drive(1, 0, 32'h0000_1000, 5'd4, "R2 ROM base");
        drive(1, 0, 32'h0000_1FFC, 5'd4, "R2 ROM last word");
        drive(1, 0, 32'h0000_1FFE, 5'd4, "R2 ROM straddles end");
        drive(1, 1, 32'h0000_0FFF, 5'd4, "R2 below ROM base");
        drive(1, 0, 32'h0200_0000, 5'd8, "R3 timer base");
        drive(1, 1, 32'h0200_BFF8, 5'd8, "R3 timer last dword");
        drive(1, 1, 32'h0200_BFFC, 5'd8, "R3 timer straddles end");
        drive(1, 1, 32'h4000_0000, 5'd8, "R4 host write 8");
        drive(1, 1, 32'h4000_0000, 5'd16, "R4 host write too wide");
        drive(1, 0, 32'h4000_0000, 5'd16, "R4 host wide read");
        drive(1, 0, 32'h4000_0004, 5'd4, "R4 host off address");
        drive(1, 0, OVL_HOST, 5'd8, "R5 timer beats host");
        drive(1, 1, OVL_HOST, 5'd4, "R5 timer beats host write");
        drive(1, 0, 32'h5000_0000, 5'd4, "R6 unmapped read");
        drive(1, 1, 32'h5000_0000, 5'd4, "R6 unmapped write");
        drive(1, 0, 32'hF000_0000, 5'd0, "R9 zero-byte read");
        drive(1, 1, 32'h4000_0000, 5'd0, "R9 zero-byte write");
        drive(0, 0, 32'h4000_0000, 5'd4, "R8 idle on host");
        @(posedge clk);
        wait (sb_q.size() == 0);
        @(posedge clk);
        finish_run();
    end

endmodule